// File: doc/BRIEF.md
# SPI Flash to Memory Boot Copier

After reset this block copies the beginning of a serial Flash device into system memory while the processor is held in reset. It opens an SPI read at Flash address zero, streams bytes continuously under a single chip select, gathers every four bytes into a 32-bit word and writes each word to memory as a single Wishbone write. The processor hold output drops once the last word has been accepted.

The destination word address and the copy length in bytes are fixed by parameters. They are loaded into a working address register and a remaining-word counter on every reset. The memory address bus carries the working word address shifted up by two, so it is a byte address. Tying the enable input low bypasses the copy: the processor is then released as soon as reset ends and the Flash and memory ports stay quiet.

Top module: `spi_boot_copier`

## Requirements
- R1: With `boot_en` high when reset ends, `spi_cs_n` goes low and the first 32 bits shifted out on `spi_mosi` are the read command 0x03 and then a 24-bit address of zero, most significant bit first, taken by the Flash on rising `spi_sck`.
- R2: Four consecutive Flash bytes make one memory word, with the earliest byte in bits 7:0 and the fourth byte in bits 31:24.
- R3: The number of words written is the byte length rounded up to a whole word (22 bytes gives 6 words). After the last write no further write starts and `spi_cs_n` returns high.
- R4: The first write goes to word address `START_WORD` (low 18 bits), each later write to the next word, wrapping modulo 2^18. `wb_adr` is the word address followed by two zero bits.
- R5: During every write `wb_cyc`, `wb_stb` and `wb_we` are high and `wb_sel` is 4'hF, and address and data stay unchanged until `wb_ack` is seen, whatever the acknowledge latency.
- R6: `cpu_hold` is high while `rst` is high and stays high until the last word write is acknowledged; it is low from then on.
- R7: With `boot_en` low when reset ends, `cpu_hold` falls within two clock cycles, `spi_cs_n` stays high and no memory write takes place.
- R8: `mem_rst` equals `rst`.
- R9: A reset in the middle of a copy aborts it; the following copy starts again at Flash address zero, at `START_WORD` and with the full word count.
- R10: `spi_sck` idles low and each of its half periods lasts `CLK_HALF` system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| boot_en | input | 1 | High: perform the copy after reset; low: bypass it |
| cpu_hold | output | 1 | Keeps the processor in reset while high |
| mem_rst | output | 1 | Reset for the memory side, equal to `rst` |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the Flash |
| spi_miso | input | 1 | Serial data from the Flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| wb_cyc | output | 1 | Wishbone cycle |
| wb_stb | output | 1 | Wishbone strobe |
| wb_we | output | 1 | Wishbone write enable |
| wb_sel | output | 4 | Byte selects, all high on every write |
| wb_adr | output | 20 | Byte address of the word being written |
| wb_dat_o | output | 32 | Word being written |
| wb_ack | input | 1 | Wishbone acknowledge |

## Verification
The assertions watch, on every cycle, the bus attributes of a write, the stability of address and data while a write waits for its acknowledge, the one-word address step between consecutive writes (including the wrap), the quiet ports once the processor is released, the idle-low serial clock outside a transfer and the fact that a released processor is never held again. What was read from the Flash, the byte order inside a word, the command and address bits, the total word count, the serial clock rate and the restart after a reset mid-copy can only be shown by the bench's scenarios, which compare the memory writes against a Flash model with known contents.

// File: rtl/boot_copier_pkg.sv
`timescale 1ns/1ps
package boot_copier_pkg;

  typedef enum logic [2:0] {
    ST_START,
    ST_HDR,
    ST_READ,
    ST_WRITE,
    ST_DONE
  } boot_state_t;

  localparam logic [7:0] FLASH_READ_CMD = 8'h03;
  localparam int unsigned HDR_BYTES     = 4;
  localparam int unsigned WORD_BYTES    = 4;

  // Byte length rounded up to whole 32-bit words.
  function automatic int unsigned words_for_bytes(input int unsigned nbytes);
    return (nbytes + WORD_BYTES - 1) / WORD_BYTES;
  endfunction

  // Little-endian placement: lane 0 lands in bits 7:0.
  function automatic logic [31:0] place_byte(input logic [31:0] word,
                                             input logic [1:0]  lane,
                                             input logic [7:0]  data);
    logic [31:0] r;
    r = word;
    r[lane*8 +: 8] = data;
    return r;
  endfunction

endpackage

// File: rtl/boot_spi_shifter.sv
`timescale 1ns/1ps
// One SPI mode-0 byte exchange, MSB first. Serial clock half period is
// CLK_HALF system clocks.
module boot_spi_shifter #(
  parameter int unsigned CLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sck,
  output logic       mosi,
  input  logic       miso
);
  localparam int unsigned DIV_W = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_HALF - 1);

  logic             busy;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sh;
  logic [7:0]       rx_sh;
  logic             half_tick;

  assign half_tick = busy && (div_cnt == DIV_LAST);
  assign mosi      = tx_sh[7];
  assign rx_byte   = rx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      div_cnt <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_sh   <= '0;
      sck     <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy    <= 1'b1;
        div_cnt <= '0;
        bit_cnt <= '0;
        tx_sh   <= tx_byte;
        sck     <= 1'b0;
      end else if (busy) begin
        div_cnt <= half_tick ? '0 : div_cnt + 1'b1;
        if (half_tick) begin
          if (!sck) begin
            sck   <= 1'b1;
            rx_sh <= {rx_sh[6:0], miso};
          end else begin
            sck   <= 1'b0;
            tx_sh <= {tx_sh[6:0], 1'b0};
            if (bit_cnt == 3'd7) begin
              busy <= 1'b0;
              done <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/boot_dest_counters.sv
`timescale 1ns/1ps
// Destination word address and remaining-word count, both reloaded on reset.
module boot_dest_counters #(
  parameter int unsigned WADDR_W    = 18,
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned START_WORD = 0,
  parameter int unsigned WORDS      = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               advance,
  output logic [WADDR_W-1:0] cur_waddr,
  output logic [CNT_W-1:0]   words_left
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_waddr  <= WADDR_W'(START_WORD);
      words_left <= CNT_W'(WORDS);
    end else if (advance) begin
      cur_waddr  <= cur_waddr + 1'b1;
      words_left <= words_left - 1'b1;
    end
  end
endmodule

// File: rtl/spi_boot_copier.sv
`timescale 1ns/1ps
module spi_boot_copier
  import boot_copier_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned START_WORD = 32'h00100,
  parameter int unsigned SIZE_BYTES = 1024,
  parameter int unsigned CLK_HALF   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              boot_en,
  output logic              cpu_hold,
  output logic              mem_rst,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [3:0]        wb_sel,
  output logic [ADDR_W-1:0] wb_adr,
  output logic [31:0]       wb_dat_o,
  input  logic              wb_ack
);
  localparam int unsigned WADDR_W = ADDR_W - 2;
  localparam int unsigned WORDS   = words_for_bytes(SIZE_BYTES);
  localparam int unsigned CNT_W   = $clog2(WORDS + 2);

  boot_state_t        state;
  logic [1:0]         hdr_idx;
  logic [1:0]         lane;
  logic [31:0]        word_buf;
  logic               spi_start;
  logic [7:0]         spi_tx;
  logic               spi_done;
  logic [7:0]         spi_rx;
  logic [WADDR_W-1:0] cur_waddr;
  logic [CNT_W-1:0]   words_left;

  // Named events for the checker.
  logic word_fire;
  logic last_word;
  assign word_fire = (state == ST_WRITE) && wb_ack;
  assign last_word = (words_left == CNT_W'(1));

  boot_spi_shifter #(.CLK_HALF(CLK_HALF)) u_spi (
    .clk     (clk),
    .rst     (rst),
    .start   (spi_start),
    .tx_byte (spi_tx),
    .done    (spi_done),
    .rx_byte (spi_rx),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  boot_dest_counters #(
    .WADDR_W    (WADDR_W),
    .CNT_W      (CNT_W),
    .START_WORD (START_WORD),
    .WORDS      (WORDS)
  ) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .advance    (word_fire),
    .cur_waddr  (cur_waddr),
    .words_left (words_left)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_START;
      spi_cs_n  <= 1'b1;
      spi_start <= 1'b0;
      spi_tx    <= '0;
      hdr_idx   <= '0;
      lane      <= '0;
      word_buf  <= '0;
    end else begin
      spi_start <= 1'b0;
      case (state)
        ST_START: begin
          if (!boot_en || words_left == '0) begin
            state <= ST_DONE;
          end else begin
            spi_cs_n  <= 1'b0;
            spi_tx    <= FLASH_READ_CMD;
            spi_start <= 1'b1;
            hdr_idx   <= '0;
            state     <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (spi_done) begin
            spi_tx    <= 8'h00;
            spi_start <= 1'b1;
            if (hdr_idx == 2'(HDR_BYTES - 1)) begin
              lane  <= '0;
              state <= ST_READ;
            end else begin
              hdr_idx <= hdr_idx + 1'b1;
            end
          end
        end
        ST_READ: begin
          if (spi_done) begin
            word_buf <= place_byte(word_buf, lane, spi_rx);
            if (lane == 2'(WORD_BYTES - 1)) begin
              state <= ST_WRITE;
            end else begin
              lane      <= lane + 1'b1;
              spi_tx    <= 8'h00;
              spi_start <= 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (wb_ack) begin
            if (last_word) begin
              state    <= ST_DONE;
              spi_cs_n <= 1'b1;
            end else begin
              lane      <= '0;
              spi_tx    <= 8'h00;
              spi_start <= 1'b1;
              state     <= ST_READ;
            end
          end
        end
        ST_DONE: state <= ST_DONE;
        default: state <= ST_DONE;
      endcase
    end
  end

  assign cpu_hold = rst || (state != ST_DONE);
  assign mem_rst  = rst;
  assign wb_cyc   = (state == ST_WRITE);
  assign wb_stb   = (state == ST_WRITE);
  assign wb_we    = (state == ST_WRITE);
  assign wb_sel   = (state == ST_WRITE) ? 4'hF : 4'h0;
  assign wb_adr   = {cur_waddr, 2'b00};
  assign wb_dat_o = word_buf;

endmodule

// File: rtl/boot_copier_chk.sv
`timescale 1ns/1ps
module boot_copier_chk #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_hold,
  input logic              spi_cs_n,
  input logic              spi_sck,
  input logic              wb_cyc,
  input logic              wb_stb,
  input logic              wb_we,
  input logic [3:0]        wb_sel,
  input logic [ADDR_W-1:0] wb_adr,
  input logic [31:0]       wb_dat_o,
  input logic              wb_ack,
  input logic              word_fire,
  input logic [CNT_W-1:0]  words_left
);
  logic              seen_ack;
  logic [ADDR_W-1:0] nxt_adr;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_ack <= 1'b0;
      nxt_adr  <= '0;
    end else if (wb_stb && wb_ack) begin
      seen_ack <= 1'b1;
      nxt_adr  <= wb_adr + ADDR_W'(4);
    end
  end

  // R5
  write_attr_chk: assert property (@(posedge clk) disable iff (rst)
    wb_stb |-> (wb_cyc && wb_we && wb_sel == 4'hF && wb_adr[1:0] == 2'b00));

  // R5
  write_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wb_stb && !wb_ack) |=> (wb_stb && $stable(wb_adr) && $stable(wb_dat_o)));

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(wb_stb) && seen_ack) |-> (wb_adr == nxt_adr));

  // R3
  count_live_chk: assert property (@(posedge clk) disable iff (rst)
    word_fire |-> (words_left != '0));

  // R6
  release_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_hold |-> (spi_cs_n && !wb_cyc));

  // R6
  release_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !cpu_hold |=> !cpu_hold);

  // R10
  sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck);

endmodule

bind spi_boot_copier boot_copier_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_hold   (cpu_hold),
  .spi_cs_n   (spi_cs_n),
  .spi_sck    (spi_sck),
  .wb_cyc     (wb_cyc),
  .wb_stb     (wb_stb),
  .wb_we      (wb_we),
  .wb_sel     (wb_sel),
  .wb_adr     (wb_adr),
  .wb_dat_o   (wb_dat_o),
  .wb_ack     (wb_ack),
  .word_fire  (word_fire),
  .words_left (words_left)
);

// File: tb/sim_spi_boot_copier.sv
`timescale 1ns/1ps
module sim_spi_boot_copier;
  localparam int unsigned ADDR_W     = 20;
  localparam int unsigned START_WORD = 32'h3FFFD;
  localparam int unsigned SIZE_BYTES = 22;
  localparam int unsigned CLK_HALF   = 2;
  localparam int unsigned NWORDS     = 6;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              boot_en = 1'b1;
  logic              cpu_hold, mem_rst;
  logic              spi_sck, spi_mosi, spi_miso, spi_cs_n;
  logic              wb_cyc, wb_stb, wb_we;
  logic [3:0]        wb_sel;
  logic [ADDR_W-1:0] wb_adr;
  logic [31:0]       wb_dat_o;
  logic              wb_ack = 1'b0;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  spi_boot_copier #(
    .ADDR_W     (ADDR_W),
    .START_WORD (START_WORD),
    .SIZE_BYTES (SIZE_BYTES),
    .CLK_HALF   (CLK_HALF)
  ) u0 (
    .clk      (clk),
    .rst      (rst),
    .boot_en  (boot_en),
    .cpu_hold (cpu_hold),
    .mem_rst  (mem_rst),
    .spi_sck  (spi_sck),
    .spi_mosi (spi_mosi),
    .spi_miso (spi_miso),
    .spi_cs_n (spi_cs_n),
    .wb_cyc   (wb_cyc),
    .wb_stb   (wb_stb),
    .wb_we    (wb_we),
    .wb_sel   (wb_sel),
    .wb_adr   (wb_adr),
    .wb_dat_o (wb_dat_o),
    .wb_ack   (wb_ack)
  );

  // ---------------- Flash model ----------------
  function automatic logic [7:0] flash_byte(input int idx);
    return 8'((idx * 37 + 5) & 255);
  endfunction

  function automatic logic flash_bit(input int k);
    logic [7:0] b;
    b = flash_byte(k / 8);
    return b[7 - (k % 8)];
  endfunction

  int          rise_cnt = 0;
  logic [31:0] hdr_bits = '0;
  int          cyc_now = 0;
  int          last_rise = 0;
  int          sck_period = 0;
  logic        cs_seen_low = 1'b0;

  always @(posedge clk) cyc_now <= cyc_now + 1;

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      rise_cnt <= 0;
    end else begin
      if (rise_cnt < 32) hdr_bits <= {hdr_bits[30:0], spi_mosi};
      if (rise_cnt == 1) sck_period <= cyc_now - last_rise;
      last_rise <= cyc_now;
      rise_cnt  <= rise_cnt + 1;
    end
  end

  always @(negedge spi_cs_n) cs_seen_low <= 1'b1;

  assign spi_miso = (!spi_cs_n && rise_cnt >= 32) ? flash_bit(rise_cnt - 32) : 1'b0;

  // ---------------- Memory model ----------------
  int          ack_lat = 0;
  int          lat_cnt = 0;
  int          wr_n = 0;
  int          attr_bad = 0;
  int          hold_low_at_wr = 0;
  logic [19:0] wr_adr [0:15];
  logic [31:0] wr_dat [0:15];

  always @(posedge clk) begin
    wb_ack <= 1'b0;
    if (rst) begin
      wr_n <= 0; attr_bad <= 0; hold_low_at_wr <= 0; lat_cnt <= 0;
    end else if (wb_cyc && wb_stb && !wb_ack) begin
      if (lat_cnt >= ack_lat) begin
        wb_ack  <= 1'b1;
        lat_cnt <= 0;
        if (wr_n < 16) begin
          wr_adr[wr_n] <= wb_adr;
          wr_dat[wr_n] <= wb_dat_o;
        end
        wr_n <= wr_n + 1;
        if (!(wb_we && wb_sel == 4'hF)) attr_bad <= attr_bad + 1;
        if (!cpu_hold) hold_low_at_wr <= hold_low_at_wr + 1;
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end else begin
      lat_cnt <= 0;
    end
  end

  // ---------------- Helpers ----------------
  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply_reset(input logic en);
    @(negedge clk);
    rst = 1'b1;
    boot_en = en;
    cs_seen_low = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_release(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!cpu_hold) begin ok = 1'b1; break; end
    end
  endtask

  function automatic logic [31:0] exp_word(input int k);
    return {flash_byte(4*k+3), flash_byte(4*k+2), flash_byte(4*k+1), flash_byte(4*k)};
  endfunction

  function automatic logic [19:0] exp_adr(input int k);
    logic [17:0] w;
    w = 18'(START_WORD + k);
    return {w, 2'b00};
  endfunction

  // ---------------- Scenarios ----------------
  task automatic t_reset_state();
    @(negedge clk);
    rst = 1'b1;
    boot_en = 1'b1;
    repeat (2) @(negedge clk);
    check(cpu_hold == 1'b1, "R6", "hold during reset", 32'(cpu_hold), 32'd1);
    check(mem_rst == 1'b1, "R8", "mem_rst during reset", 32'(mem_rst), 32'd1);
    check(spi_cs_n == 1'b1 && wb_cyc == 1'b0, "R6", "quiet ports in reset",
          {30'd0, spi_cs_n, wb_cyc}, 32'd2);
    check(spi_sck == 1'b0, "R10", "sck idle in reset", 32'(spi_sck), 32'd0);
  endtask

  task automatic t_full_copy(input int lat);
    bit ok;
    ack_lat = lat;
    apply_reset(1'b1);
    check(mem_rst == 1'b0, "R8", "mem_rst after release", 32'(mem_rst), 32'd0);
    wait_release(ok);
    check(ok, "R6", "hold released after copy", 32'(ok), 32'd1);
    check(hdr_bits == 32'h0300_0000, "R1", "command and address bits", hdr_bits, 32'h0300_0000);
    check(wr_n == NWORDS, "R3", "word count", 32'(wr_n), 32'(NWORDS));
    check(hold_low_at_wr == 0, "R6", "hold high at each write", 32'(hold_low_at_wr), 32'd0);
    check(attr_bad == 0, "R5", "write attributes", 32'(attr_bad), 32'd0);
    check(spi_cs_n == 1'b1, "R3", "cs released at end", 32'(spi_cs_n), 32'd1);
    check(sck_period == 2*CLK_HALF, "R10", "sck period in clocks", 32'(sck_period), 32'(2*CLK_HALF));
    for (int k = 0; k < NWORDS; k++) begin
      check(wr_adr[k] == exp_adr(k), "R4", $sformatf("address of word %0d", k),
            32'(wr_adr[k]), 32'(exp_adr(k)));
      check(wr_dat[k] == exp_word(k), "R2", $sformatf("data of word %0d", k),
            wr_dat[k], exp_word(k));
    end
    repeat (50) @(negedge clk);
    check(wr_n == NWORDS && !cpu_hold, "R3", "no writes after finish", 32'(wr_n), 32'(NWORDS));
  endtask

  task automatic t_disabled();
    apply_reset(1'b0);
    repeat (2) @(negedge clk);
    check(cpu_hold == 1'b0, "R7", "hold drops when bypassed", 32'(cpu_hold), 32'd0);
    repeat (300) @(negedge clk);
    check(wr_n == 0, "R7", "no writes when bypassed", 32'(wr_n), 32'd0);
    check(cs_seen_low == 1'b0 && spi_cs_n == 1'b1, "R7", "Flash untouched when bypassed",
          32'(cs_seen_low), 32'd0);
    boot_en = 1'b1;
    repeat (5) @(negedge clk);
    check(cpu_hold == 1'b0 && !cs_seen_low, "R7", "late enable without reset ignored",
          32'(cpu_hold), 32'd0);
  endtask

  task automatic t_mid_reset();
    bit ok;
    ack_lat = 1;
    apply_reset(1'b1);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (wr_n >= 2) break;
    end
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(cpu_hold == 1'b1 && mem_rst == 1'b1, "R9", "hold and mem_rst on abort",
          {30'd0, cpu_hold, mem_rst}, 32'd3);
    check(spi_cs_n == 1'b1, "R9", "Flash deselected on abort", 32'(spi_cs_n), 32'd1);
    @(negedge clk);
    rst = 1'b0;
    wait_release(ok);
    check(ok && wr_n == NWORDS, "R9", "restarted copy word count", 32'(wr_n), 32'(NWORDS));
    check(wr_adr[0] == exp_adr(0), "R9", "restart address", 32'(wr_adr[0]), 32'(exp_adr(0)));
    check(wr_dat[0] == exp_word(0), "R9", "restart Flash offset", wr_dat[0], exp_word(0));
    check(hdr_bits == 32'h0300_0000, "R9", "restart command", hdr_bits, 32'h0300_0000);
  endtask

  // ---------------- Run ----------------
  initial begin
    t_reset_state();
    t_full_copy(0);
    t_full_copy(3);
    t_disabled();
    t_mid_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule